// File: doc/BRIEF.md
# Vertex attribute fetch address generator

This block turns one vertex number into the sequence of memory read requests that a vertex loader needs. A 64-bit attribute descriptor tells it how many attributes to visit, which of them read memory, and, for each attribute that reads memory, the component format and the component count. Alongside the descriptor, each attribute has its own base address and byte stride.

After a start pulse the block visits the attributes in turn. An attribute that is switched to its fallback value produces a one-cycle default-select strobe and no memory traffic. Every other attribute issues one read request per component over a valid/ready handshake. Each request carries the byte address, the access size, a sign-extension flag, the attribute number and the component number. A done pulse follows the last item. Returning read data and converting it to float are handled further downstream.

Top module: `vtx_fetch_addr_gen`

## Requirements
- R1: After reset, `req_valid_o`, `dflt_stb_o` and `done_o` are all 0.
- R2: Attributes are visited in ascending order from 0 up to and including the value held in descriptor bits [63:60]. Every visited attribute produces exactly one default strobe or at least one accepted request.
- R3: An attribute i below 12 whose mask bit, descriptor bit 48+i, is 1 produces one `dflt_stb_o` cycle, with `dflt_attr_o` = i, and no request.
- R4: An attribute numbered 12 to 15 always takes its default value and never appears on `req_attr_o`.
- R5: A fetched attribute i issues exactly (descriptor bits [4i+3:4i+2]) + 1 requests, with `req_comp_o` counting up from 0.
- R6: The address of component c of attribute i for vertex v is base[i] + stride[i]·v + c·size, wrapped to the address width. The size is taken from the format in descriptor bits [4i+1:4i]: 0 (signed byte) and 1 (unsigned byte) give 1 byte, 2 (signed 16-bit) gives 2, and 3 (32-bit float) gives 4. `req_bytes_o` carries this size.
- R7: `req_signed_o` is 1 for formats 0 and 2, and 0 for formats 1 and 3.
- R8: While `req_valid_o` is 1 and `req_ready_i` is 0, every request field stays unchanged into the next cycle.
- R9: `done_o` is a single-cycle pulse in the cycle after the last accepted request or the last default strobe of a run. No request or strobe is active in that cycle.
- R10: A start pulse that arrives while a run is in progress is ignored. The run in progress continues with its own vertex number and descriptor.
- R11: `dflt_stb_o` and `req_valid_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; ignored while busy |
| vtx_i | input | VTX_W | Vertex number, captured at start |
| desc_i | input | 64 | Attribute descriptor, captured at start |
| base_i | input | 12·ADDR_W | Base address per fetchable attribute, attribute i at slice i |
| stride_i | input | 12·STRIDE_W | Byte stride per fetchable attribute, attribute i at slice i |
| req_valid_o | output | 1 | Read request present |
| req_ready_i | input | 1 | Read request accepted when high with valid |
| req_addr_o | output | ADDR_W | Byte address of the component |
| req_bytes_o | output | 3 | Access size in bytes (1, 2 or 4) |
| req_signed_o | output | 1 | Component needs sign extension |
| req_attr_o | output | 4 | Attribute number of the request |
| req_comp_o | output | 2 | Component number of the request |
| dflt_stb_o | output | 1 | Attribute takes its fallback value this cycle |
| dflt_attr_o | output | 4 | Attribute number for the default strobe |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The checks inside the RTL assume that the base and stride inputs stay fixed for the whole of a run, because only the descriptor and the vertex number are captured at start. They also assume that the consumer asserts ready in any pattern, with no link to valid. The bench changes base and stride only between runs, while the block is idle. It drives ready with always-high, alternating and one-in-three stall patterns. It sweeps every format and count combination at the smallest, unit and largest vertex numbers, and it injects a start pulse with a different vertex in the middle of a run.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
    // Descriptor geometry: fixed by the descriptor layout
    localparam int LOADED    = 12;               // attributes with a format entry
    localparam int SLOTS     = 16;               // attribute number space
    localparam int ENTRY_W   = 4;                // format + count per attribute
    localparam int MASK_LSB  = LOADED * ENTRY_W; // 48
    localparam int USED_W    = MASK_LSB + LOADED; // 60: entries + mask
    localparam int DESC_W    = 64;
    localparam int ATTR_W    = $clog2(SLOTS);

    typedef enum logic [1:0] {
        FMT_S8  = 2'd0,
        FMT_U8  = 2'd1,
        FMT_S16 = 2'd2,
        FMT_F32 = 2'd3
    } vfa_fmt_e;

    typedef struct packed {
        logic      dflt;
        vfa_fmt_e  fmt;
        logic [1:0] cnt_m1;
    } vfa_attr_t;

    function automatic logic [2:0] elem_bytes(input vfa_fmt_e f);
        case (f)
            FMT_F32: elem_bytes = 3'd4;
            FMT_S16: elem_bytes = 3'd2;
            default: elem_bytes = 3'd1;
        endcase
    endfunction

    function automatic logic fmt_signed(input vfa_fmt_e f);
        fmt_signed = (f == FMT_S8) || (f == FMT_S16);
    endfunction
endpackage

// File: rtl/vfa_desc_decode.sv
module vfa_desc_decode
    import vfa_pkg::*;
(
    input  logic [USED_W-1:0] desc_i,
    output vfa_attr_t         tbl_o [SLOTS]
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < LOADED) begin : g_ld
            assign tbl_o[i] = '{dflt:   desc_i[MASK_LSB + i],
                                fmt:    vfa_fmt_e'(desc_i[ENTRY_W*i +: 2]),
                                cnt_m1: desc_i[ENTRY_W*i + 2 +: 2]};
        end else begin : g_hi
            assign tbl_o[i] = '{dflt: 1'b1, fmt: FMT_S8, cnt_m1: 2'd0};
        end
    end
endmodule

// File: rtl/vfa_addr_calc.sv
module vfa_addr_calc
    import vfa_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 8,
    parameter int VTX_W    = 16
) (
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [VTX_W-1:0]    vtx_i,
    input  logic [1:0]          comp_i,
    input  vfa_fmt_e            fmt_i,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int PROD_W = STRIDE_W + VTX_W;

    logic [PROD_W-1:0] vtx_off;
    logic [4:0]        comp_off;

    always_comb begin
        vtx_off  = {{VTX_W{1'b0}}, stride_i} * {{STRIDE_W{1'b0}}, vtx_i};
        comp_off = {3'b000, comp_i} * {2'b00, elem_bytes(fmt_i)};
        addr_o   = base_i + ADDR_W'(vtx_off) + ADDR_W'(comp_off);
    end
endmodule

// File: rtl/vtx_fetch_addr_gen.sv
module vtx_fetch_addr_gen
    import vfa_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 8,
    parameter int VTX_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [VTX_W-1:0]             vtx_i,
    input  logic [DESC_W-1:0]            desc_i,
    input  logic [LOADED*ADDR_W-1:0]     base_i,
    input  logic [LOADED*STRIDE_W-1:0]   stride_i,
    output logic                         req_valid_o,
    input  logic                         req_ready_i,
    output logic [ADDR_W-1:0]            req_addr_o,
    output logic [2:0]                   req_bytes_o,
    output logic                         req_signed_o,
    output logic [ATTR_W-1:0]            req_attr_o,
    output logic [1:0]                   req_comp_o,
    output logic                         dflt_stb_o,
    output logic [ATTR_W-1:0]            dflt_attr_o,
    output logic                         done_o
);
    localparam int LD_W = $clog2(LOADED);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ATTR_W-1:0] attr;
        logic [1:0]        comp;
        logic [ATTR_W-1:0] last;
        logic [VTX_W-1:0]  vtx;
        logic [USED_W-1:0] desc;
    } state_t;

    state_t s_d, s_q;

    // Per-attribute decode of the captured descriptor
    vfa_attr_t tbl [SLOTS];
    vfa_desc_decode u_dec (.desc_i(s_q.desc), .tbl_o(tbl));

    // Base and stride unpacking
    logic [ADDR_W-1:0]   base_arr   [LOADED];
    logic [STRIDE_W-1:0] stride_arr [LOADED];
    for (genvar i = 0; i < LOADED; i++) begin : g_unpack
        assign base_arr[i]   = base_i[i*ADDR_W +: ADDR_W];
        assign stride_arr[i] = stride_i[i*STRIDE_W +: STRIDE_W];
    end

    vfa_attr_t       cur;
    logic [LD_W-1:0] ld_sel;
    logic            fetch_now;
    logic            dflt_now;
    logic            accept;
    logic            comp_last;
    logic            step_attr;

    always_comb begin
        cur       = tbl[s_q.attr];
        ld_sel    = (s_q.attr < ATTR_W'(LOADED)) ? s_q.attr[LD_W-1:0] : '0;
        fetch_now = s_q.busy && !cur.dflt;
        dflt_now  = s_q.busy && cur.dflt;
        accept    = fetch_now && req_ready_i;
        comp_last = (s_q.comp == cur.cnt_m1);
        step_attr = dflt_now || (accept && comp_last);
    end

    vfa_addr_calc #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VTX_W(VTX_W)
    ) u_addr (
        .base_i  (base_arr[ld_sel]),
        .stride_i(stride_arr[ld_sel]),
        .vtx_i   (s_q.vtx),
        .comp_i  (s_q.comp),
        .fmt_i   (cur.fmt),
        .addr_o  (req_addr_o)
    );

    // Next-state logic
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.attr = '0;
                s_d.comp = '0;
                s_d.last = desc_i[DESC_W-1 -: ATTR_W];
                s_d.vtx  = vtx_i;
                s_d.desc = desc_i[USED_W-1:0];
            end
        end else begin
            if (accept && !comp_last) begin
                s_d.comp = s_q.comp + 2'd1;
            end
            if (step_attr) begin
                s_d.comp = '0;
                if (s_q.attr == s_q.last) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.attr = s_q.attr + ATTR_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_valid_o  = fetch_now;
    assign req_bytes_o  = elem_bytes(cur.fmt);
    assign req_signed_o = fmt_signed(cur.fmt);
    assign req_attr_o   = s_q.attr;
    assign req_comp_o   = s_q.comp;
    assign dflt_stb_o   = dflt_now;
    assign dflt_attr_o  = s_q.attr;
    assign done_o       = s_q.done;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
            && $stable(req_attr_o) && $stable(req_comp_o) && $stable(req_bytes_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o && !dflt_stb_o);

    // R4
    fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> req_attr_o < ATTR_W'(LOADED));

    // R6
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> $countones(req_bytes_o) == 1);

    // R10
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && start_i |=> $stable(s_q.vtx) && $stable(s_q.last));
endmodule

// File: tb/vtx_fetch_addr_gen_bench.sv
module vtx_fetch_addr_gen_bench;
    localparam int ADDR_W = 32;
    localparam int STR_W  = 8;
    localparam int VTX_W  = 16;
    localparam int NLD    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VTX_W-1:0] vtx_drv = '0;
    logic [63:0] desc = '0;
    logic [NLD*ADDR_W-1:0] base_f = '0;
    logic [NLD*STR_W-1:0]  str_f  = '0;
    logic req_ready = 1'b0;

    logic req_valid, req_signed, dflt_stb, done;
    logic [ADDR_W-1:0] req_addr;
    logic [2:0] req_bytes;
    logic [3:0] req_attr, dflt_attr;
    logic [1:0] req_comp;

    always #5 clk = ~clk;

    vtx_fetch_addr_gen u_vtx_fetch_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vtx_i(vtx_drv),
        .desc_i(desc), .base_i(base_f), .stride_i(str_f),
        .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_addr_o(req_addr), .req_bytes_o(req_bytes),
        .req_signed_o(req_signed), .req_attr_o(req_attr),
        .req_comp_o(req_comp), .dflt_stb_o(dflt_stb),
        .dflt_attr_o(dflt_attr), .done_o(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          exp_n;
    logic        exp_dflt  [64];
    logic [3:0]  exp_attr  [64];
    logic [1:0]  exp_comp  [64];
    logic [31:0] exp_addr  [64];
    logic [2:0]  exp_bytes [64];
    logic        exp_sgn   [64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference sequence from the requirements
    task automatic build_expect(input logic [VTX_W-1:0] v);
        int last;
        exp_n = 0;
        last = int'(desc[63:60]);
        for (int i = 0; i <= last; i++) begin
            if (i >= NLD || desc[48+i]) begin
                exp_dflt[exp_n] = 1'b1;
                exp_attr[exp_n] = 4'(i);
                exp_n++;
            end else begin
                logic [1:0] f;
                logic [1:0] cm1;
                logic [2:0] eb;
                f   = desc[4*i +: 2];
                cm1 = desc[4*i+2 +: 2];
                eb  = (f == 2'd3) ? 3'd4 : (f == 2'd2) ? 3'd2 : 3'd1;
                for (int c = 0; c <= int'(cm1); c++) begin
                    exp_dflt[exp_n]  = 1'b0;
                    exp_attr[exp_n]  = 4'(i);
                    exp_comp[exp_n]  = 2'(c);
                    exp_bytes[exp_n] = eb;
                    exp_sgn[exp_n]   = (f == 2'd0) || (f == 2'd2);
                    exp_addr[exp_n]  = base_f[i*ADDR_W +: ADDR_W]
                                     + 32'(str_f[i*STR_W +: STR_W]) * 32'(v)
                                     + 32'(c) * 32'(eb);
                    exp_n++;
                end
            end
        end
    endtask

    function automatic logic rdy_pat(input int mode, input int cyc);
        case (mode)
            1:       return (cyc % 2) == 1;
            2:       return (cyc % 3) != 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic run_case(input logic [VTX_W-1:0] v, input int mode, input bit poke);
        int k;
        int cyc;
        bit stalled;
        logic [31:0] prev_addr;
        string atag;
        atag = poke ? "R10" : "R6";
        build_expect(v);
        @(negedge clk);
        vtx_drv = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0; stalled = 0; prev_addr = '0;
        while (k < exp_n && cyc < 1000) begin
            req_ready = rdy_pat(mode, cyc);
            if (poke && cyc == 1) begin
                start = 1'b1;
                vtx_drv = v ^ 16'h00ff;
            end else begin
                start = 1'b0;
            end
            #1;
            chk("R11", 32'(req_valid && dflt_stb), 32'd0);
            if (stalled) chk("R8", req_addr, prev_addr);
            if (dflt_stb) begin
                chk(exp_dflt[k] ? ((exp_attr[k] >= 4'd12) ? "R4" : "R3") : "R2",
                    {28'd0, dflt_attr}, exp_dflt[k] ? {28'd0, exp_attr[k]} : 32'hFFFF_FFFF);
                k++;
            end else if (req_valid && req_ready) begin
                chk("R2", {31'd0, exp_dflt[k]}, 32'd0);
                chk("R2", {28'd0, req_attr}, {28'd0, exp_attr[k]});
                chk("R5", {30'd0, req_comp}, {30'd0, exp_comp[k]});
                chk(atag, req_addr, exp_addr[k]);
                chk("R6", {29'd0, req_bytes}, {29'd0, exp_bytes[k]});
                chk("R7", {31'd0, req_signed}, {31'd0, exp_sgn[k]});
                k++;
            end
            stalled = req_valid && !req_ready;
            prev_addr = req_addr;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        req_ready = 1'b0;
        chk("R2", 32'(k), 32'(exp_n));
        #1;
        chk("R9", {31'd0, done}, 32'd1);
        chk("R9", {31'd0, req_valid || dflt_stb}, 32'd0);
        @(negedge clk);
        #1;
        chk("R9", {31'd0, done}, 32'd0);
        chk("R10", {31'd0, req_valid || dflt_stb}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NLD; i++) begin
            base_f[i*ADDR_W +: ADDR_W] = 32'h4000_0000 + 32'(i) * 32'h0000_1234;
            str_f[i*STR_W +: STR_W]    = 8'(i * 11 + 5);
        end
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk("R1", {29'd0, req_valid, dflt_stb, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", {29'd0, req_valid, dflt_stb, done}, 32'd0);

        // All twelve fetched, varied formats and counts
        desc = '0;
        for (int i = 0; i < NLD; i++) begin
            desc[4*i +: 2]   = 2'(i % 4);
            desc[4*i+2 +: 2] = 2'((i / 4 + i) % 4);
        end
        desc[63:60] = 4'd11;
        run_case(16'd5, 0, 0);

        // Mixed mask, attributes 12..15 included, alternating ready
        desc[59:48] = 12'b1010_0101_1010;
        desc[63:60] = 4'd15;
        run_case(16'd300, 1, 0);

        // Single default-only attribute
        desc = '0;
        desc[48] = 1'b1;
        run_case(16'd7, 2, 0);

        // Format and count sweep at boundary vertex numbers
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < 4; c++) begin
                for (int vi = 0; vi < 3; vi++) begin
                    desc = '0;
                    desc[1:0] = 2'(f);
                    desc[3:2] = 2'(c);
                    desc[49] = 1'b1;
                    desc[63:60] = 4'd1;
                    run_case(vi == 0 ? 16'd0 : vi == 1 ? 16'd1 : 16'hFFFF, 2, 0);
                end
            end
        end

        // Start pulse while busy must be ignored
        desc = '0;
        for (int i = 0; i < 4; i++) begin
            desc[4*i +: 2]   = 2'(3 - i);
            desc[4*i+2 +: 2] = 2'd2;
        end
        desc[63:60] = 4'd3;
        run_case(16'd77, 1, 1);

        // Count past the fetchable range, no mask
        desc = '0;
        for (int i = 0; i < NLD; i++) desc[4*i +: 4] = 4'(i);
        desc[63:60] = 4'd13;
        run_case(16'd9, 0, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule